// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block sits behind the command decoder of a serial memory device. It gathers the data bytes of a memory-write command into a 32-byte page buffer. Once a frame opens with a start address, every data byte goes to the lane named by the low five address bits, and that column then steps forward. The column wraps inside the page, so a long burst overwrites lanes it loaded earlier and never moves into the next page. A per-lane valid mask records which lanes hold fresh data.

When the frame closes, the block judges it. The close must fall exactly on a byte boundary, and at least one data byte must have been loaded. A frame that passes starts one self-timed write cycle. During that cycle the loaded lanes go to the storage array one per clock, in ascending lane order, and a busy flag stays high for a fixed number of clocks. A frame that fails writes nothing. The opcode decoder and the protection checks are outside this block and reach it only as a single accept input. A new frame is refused while a write cycle is running.

Top module: `pageWriteBuffer`

## Requirements
- R1: After reset, `busy` and `arrWe` are 0.
- R2: The first byte goes to lane `startAddr[4:0]`. Each later byte goes to the next lane modulo 32. Every array write carries `arrAddr = {startAddr[12:5], lane}`, so the page bits never change within a commit.
- R3: When a burst passes the page end and loads a lane a second time, the lane is written to the array once, with the last byte loaded into it.
- R4: Only lanes loaded in the frame are written. Writes come one per clock in strictly ascending lane order. The first write appears in the cycle after the closing edge.
- R5: A frame that closes with `endOnBoundary` = 0 writes nothing and leaves `busy` at 0.
- R6: A frame that closes before any data byte was loaded writes nothing and leaves `busy` at 0.
- R7: After a valid close, `busy` rises in the next cycle and stays high for exactly TW cycles, where TW = max(WRITE_CYCLES, PAGE_BYTES+1). It is 48 with the default values.
- R8: A frame start seen while `busy` is high is refused. Its bytes and its close produce no writes and no second busy period.
- R9: A frame start with `accept` = 0 opens no frame, so its bytes and its close produce nothing.
- R10: A byte strobe in the same cycle as the frame close is loaded as the last byte of the frame and is counted for the one-byte minimum.
- R11: Byte strobes and closes seen while no frame is open have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Opens a write frame, one cycle wide |
| accept | input | 1 | Decode and protection approval, sampled with frameStart |
| startAddr | input | 13 | Start address of the frame |
| byteValid | input | 1 | A data byte is present on byteData |
| byteData | input | 8 | Data byte |
| frameEnd | input | 1 | The frame closes this cycle |
| endOnBoundary | input | 1 | The close fell on a byte boundary, sampled with frameEnd |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | 13 | Array write address |
| arrData | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
Two functions can fall in the same cycle: loading a byte and judging the frame close. The bench drives the last data byte in the same cycle as the close. It expects that byte to be written and to count for the one-byte minimum. A refused frame issued during the busy period is also checked. Its lanes must never reach the array, and the busy period must keep its single fixed length.

// File: rtl/pwbPkg.sv
package pwbPkg;
  typedef struct packed {
    logic loadStart;
    logic storeByte;
    logic startCommit;
    logic popLane;
  } pwbStrobe_t;
endpackage

// File: rtl/pwbDatapath.sv
module pwbDatapath #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pwbPkg::pwbStrobe_t    str,
  input  logic [ADDR_W-1:0]     startAddr,
  input  logic [DATA_W-1:0]     byteData,
  output logic                  maskAny,
  output logic                  pendAny,
  output logic [ADDR_W-1:0]     arrAddr,
  output logic [DATA_W-1:0]     arrData
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;

  logic [PAGE_W-1:0]     pageBase;
  logic [COL_W-1:0]      col;
  logic [PAGE_BYTES-1:0] laneMask;
  logic [PAGE_BYTES-1:0] pending;
  logic [PAGE_BYTES-1:0] storeHit;
  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [COL_W-1:0]      nextLane;

  assign storeHit = str.storeByte ? (PAGE_BYTES'(1) << col) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      col      <= '0;
      laneMask <= '0;
      pending  <= '0;
    end else begin
      if (str.loadStart) begin
        pageBase <= startAddr[ADDR_W-1:COL_W];
        col      <= startAddr[COL_W-1:0];
        laneMask <= '0;
      end else if (str.storeByte) begin
        laneMask <= laneMask | storeHit;
        col      <= col + COL_W'(1);
      end
      if (str.startCommit) begin
        pending <= laneMask | storeHit;
      end else if (str.popLane) begin
        pending[nextLane] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (str.storeByte) pageBuf[col] <= byteData;
  end

  always_comb begin
    nextLane = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
      if (pending[i]) nextLane = COL_W'(i);
    end
  end

  assign maskAny = |laneMask;
  assign pendAny = |pending;
  assign arrAddr = {pageBase, nextLane};
  assign arrData = pageBuf[nextLane];
endmodule

// File: rtl/pwbControl.sv
module pwbControl #(
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               accept,
  input  logic               byteValid,
  input  logic               frameEnd,
  input  logic               endOnBoundary,
  input  logic               maskAny,
  input  logic               pendAny,
  output pwbPkg::pwbStrobe_t str,
  output logic               busy,
  output logic               arrWe
);
  // the timer window must cover one clock per lane plus one
  localparam int TW    = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES + 1;
  localparam int TMR_W = $clog2(TW + 1);

  typedef enum logic [1:0] {IDLE, LOAD, COMMIT} pwbState_t;
  pwbState_t state, nextState;
  logic [TMR_W-1:0] timer;

  always_comb begin
    str       = '0;
    nextState = state;
    unique case (state)
      IDLE: begin
        if (frameStart && accept) begin
          str.loadStart = 1'b1;
          nextState     = LOAD;
        end
      end
      LOAD: begin
        str.storeByte = byteValid;
        if (frameEnd) begin
          if (endOnBoundary && (maskAny || byteValid)) begin
            str.startCommit = 1'b1;
            nextState       = COMMIT;
          end else begin
            nextState = IDLE;
          end
        end
      end
      COMMIT: begin
        str.popLane = pendAny;
        if (timer == TMR_W'(TW - 1)) nextState = IDLE;
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      timer <= '0;
    end else begin
      state <= nextState;
      if (str.startCommit)      timer <= '0;
      else if (state == COMMIT) timer <= timer + TMR_W'(1);
    end
  end

  assign busy  = (state == COMMIT);
  assign arrWe = busy && pendAny;
endmodule

// File: rtl/pageWriteBuffer.sv
module pageWriteBuffer #(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              accept,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              frameEnd,
  input  logic              endOnBoundary,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic              busy
);
  pwbPkg::pwbStrobe_t str;
  logic maskAny;
  logic pendAny;

  pwbControl #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .accept(accept),
    .byteValid(byteValid), .frameEnd(frameEnd), .endOnBoundary(endOnBoundary),
    .maskAny(maskAny), .pendAny(pendAny), .str(str), .busy(busy), .arrWe(arrWe)
  );

  pwbDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .startAddr(startAddr), .byteData(byteData),
    .maskAny(maskAny), .pendAny(pendAny), .arrAddr(arrAddr), .arrData(arrData)
  );
endmodule

// File: rtl/pwbChecker.sv
module pwbChecker #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameEnd,
  input logic              endOnBoundary,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr,
  input logic              busy
);
  localparam int TW    = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES + 1;
  localparam int COL_W = $clog2(PAGE_BYTES);

  int runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else       runLen <= busy ? runLen + 1 : 0;
  end

  assert_we_inside_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

  assert_ascending_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && $past(arrWe)) |-> (arrAddr[COL_W-1:0] > $past(arrAddr[COL_W-1:0])));

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && $past(arrWe)) |-> (arrAddr[ADDR_W-1:COL_W] == $past(arrAddr[ADDR_W-1:COL_W])));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == TW));

  assert_busy_after_close_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(frameEnd && endOnBoundary));

  assert_no_commit_off_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frameEnd && !endOnBoundary) |=> !busy);
endmodule

bind pageWriteBuffer pwbChecker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .endOnBoundary(endOnBoundary),
  .arrWe(arrWe), .arrAddr(arrAddr), .busy(busy)
);

// File: tb/pageWriteBuffer_tb.sv
`timescale 1ns/1ps
module pageWriteBuffer_tb;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int PAGE   = 32;
  localparam int WCYC   = 48;
  localparam int TW     = 48;
  localparam int NVEC   = 7;
  // {addr[12:0], nBytes[5:0], boundary, accept}
  localparam logic [20:0] VECS [NVEC] = '{
    {13'h0000, 6'd1,  1'b1, 1'b1},
    {13'h0123, 6'd4,  1'b1, 1'b1},
    {13'h005E, 6'd5,  1'b1, 1'b1},
    {13'h1FE5, 6'd40, 1'b1, 1'b1},
    {13'h0040, 6'd3,  1'b0, 1'b1},
    {13'h0080, 6'd0,  1'b1, 1'b1},
    {13'h0100, 6'd2,  1'b1, 1'b0}
  };

  logic clk = 0, rstN = 0;
  logic frameStart = 0, accept = 0, byteValid = 0, frameEnd = 0, endOnBoundary = 0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [DATA_W-1:0] byteData = '0;
  logic arrWe, busy;
  logic [ADDR_W-1:0] arrAddr;
  logic [DATA_W-1:0] arrData;

  int checks = 0, fails = 0;
  int wCnt = 0, busyLen = 0;
  logic [ADDR_W-1:0] wAddr [64];
  logic [DATA_W-1:0] wData [64];
  bit done = 0;

  always #2.5 clk = ~clk;

  pageWriteBuffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .accept(accept), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .frameEnd(frameEnd), .endOnBoundary(endOnBoundary),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData), .busy(busy)
  );

  always @(negedge clk) begin
    if (arrWe && wCnt < 64) begin
      wAddr[wCnt] = arrAddr;
      wData[wCnt] = arrData;
      wCnt = wCnt + 1;
    end
    if (busy) busyLen = busyLen + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 13 + i * 29 + 1);
  endfunction

  // opens (or tries to open) a frame and closes it; leaves bench at a negedge
  task automatic driveFrame(input logic [12:0] addr, input int n, input bit bnd,
                            input bit acc, input int seed, input bit endWithByte);
    @(negedge clk);
    frameStart = 1; accept = acc; startAddr = addr;
    @(negedge clk);
    frameStart = 0; accept = 0;
    for (int i = 0; i < n; i++) begin
      byteValid = 1; byteData = pat(seed, i);
      if (endWithByte && i == n - 1) begin frameEnd = 1; endOnBoundary = bnd; end
      @(negedge clk);
      byteValid = 0; frameEnd = 0; endOnBoundary = 0;
    end
    if (!(endWithByte && n > 0)) begin
      frameEnd = 1; endOnBoundary = bnd;
      @(negedge clk);
      frameEnd = 0; endOnBoundary = 0;
    end
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input logic [12:0] addr, input int n, input int seed,
                        input bit commit, input string tag);
    bit vld [PAGE];
    logic [7:0] dat [PAGE];
    int idx;
    for (int l = 0; l < PAGE; l++) begin vld[l] = 0; dat[l] = '0; end
    if (commit) begin
      for (int i = 0; i < n; i++) begin
        vld[(addr[4:0] + i) % PAGE] = 1;
        dat[(addr[4:0] + i) % PAGE] = pat(seed, i);
      end
    end
    idx = 0;
    for (int l = 0; l < PAGE; l++) begin
      if (vld[l]) begin
        if (idx < wCnt) begin
          check(wAddr[idx] == {addr[12:5], 5'(l)}, {tag, " R2 addr"}, int'(wAddr[idx]), int'({addr[12:5], 5'(l)}));
          check(wData[idx] == dat[l], {tag, " R3 data"}, int'(wData[idx]), int'(dat[l]));
        end
        idx++;
      end
    end
    check(wCnt == idx, {tag, " R4 write count"}, wCnt, idx);
    check(busyLen == (commit ? TW : 0), {tag, " R7 busy length"}, busyLen, commit ? TW : 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(arrWe == 0, "R1 arrWe after reset", arrWe, 0);
    rstN = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [12:0] a;
      int n;
      bit b, ac, cm;
      string tag;
      a = VECS[v][20:8]; n = int'(VECS[v][7:2]); b = VECS[v][1]; ac = VECS[v][0];
      cm = b && ac && (n > 0);
      case (v)
        0: tag = "R4 single";
        1: tag = "R2 mid page";
        2: tag = "R2 wrap";
        3: tag = "R3 overwrite";
        4: tag = "R5 off boundary";
        5: tag = "R6 no data";
        default: tag = "R9 not accepted";
      endcase
      wCnt = 0; busyLen = 0;
      driveFrame(a, n, b, ac, v, 1'b0);
      check(busy == cm, {tag, " R7 busy after close"}, busy, cm);
      check(arrWe == (cm && n > 0), {tag, " R4 first write timing"}, arrWe, cm);
      waitIdle();
      verify(a, n, v, cm, tag);
    end

    // R10: last byte coincides with the close
    wCnt = 0; busyLen = 0;
    driveFrame(13'h0200, 2, 1'b1, 1'b1, 20, 1'b1);
    waitIdle();
    verify(13'h0200, 2, 20, 1'b1, "R10 byte with close");
    // R10: single byte only in the closing cycle satisfies the minimum
    wCnt = 0; busyLen = 0;
    driveFrame(13'h0207, 1, 1'b1, 1'b1, 21, 1'b1);
    waitIdle();
    verify(13'h0207, 1, 21, 1'b1, "R10 lone byte with close");

    // R8: second frame during busy is refused
    wCnt = 0; busyLen = 0;
    driveFrame(13'h0300, 3, 1'b1, 1'b1, 30, 1'b0);
    driveFrame(13'h0400, 2, 1'b1, 1'b1, 31, 1'b0);
    check(busy == 1, "R8 busy during refused frame", busy, 1);
    waitIdle();
    repeat (10) @(negedge clk);
    verify(13'h0300, 3, 30, 1'b1, "R8 refused frame");

    // R11: strobes with no open frame
    wCnt = 0; busyLen = 0;
    for (int i = 0; i < 3; i++) begin
      byteValid = 1; byteData = 8'hA5;
      if (i == 2) begin frameEnd = 1; endOnBoundary = 1; end
      @(negedge clk);
    end
    byteValid = 0; frameEnd = 0; endOnBoundary = 0;
    repeat (5) @(negedge clk);
    check(busy == 0, "R11 busy stays low", busy, 0);
    check(wCnt == 0, "R11 no writes", wCnt, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule